// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block is the front end for a bank of external interrupt and event pins. Every raw pin is first brought into the clock domain by a two-stage synchroniser. Pins chosen by a parameter then pass through a digital noise filter whose window is selected at run time. Each pin's clean level is compared against a per-pin trigger condition, and a match sets a sticky interrupt flag. For the same condition, a one-cycle event strobe is issued that counters and timers can consume.

The filter and the trigger stages advance only on cycles where the cycle-rate enable is high. Flags are cleared by a host write strobe with a per-pin mask. Level triggering is only honoured on pins that a parameter marks as level-capable. On all other pins, the level codes behave as "off". The default build has six pins. Pins 0 and 1 accept all trigger types, and pins 2 to 5 accept edges only. Pin 3 is the filtered pin.

Top module: `extint_detect`

## Requirements
- R1: After reset all flags and event strobes are low.
- R2: Trigger code 1 (rising edge): on an unfiltered pin, a low-to-high change driven before clock edge k sets the flag after edge k+2 and raises the event for exactly that one cycle. A falling change leaves the flag as it was and raises no event.
- R3: Trigger code 2 (falling edge) mirrors R2 for high-to-low changes. Rising changes are ignored.
- R4: Trigger code 3 (both edges) flags either change. An unfiltered pin that is high for a single cycle produces two events on consecutive cycles.
- R5: On level-capable pins, code 4 (high) and code 5 (low) hold the flag set for as long as the level is present. A clear written during that time has no effect. The event strobe fires only on entry into the level.
- R6: On edge-only pins, codes 4 and 5 never set a flag and never raise an event. Codes 0, 6 and 7 disable a pin.
- R7: Filter select 0 sets a window of 2 enabled cycles on the filtered pin. A 1-cycle pulse is dropped and a 2-cycle pulse is accepted. An accepted change sets the flag window+3 cycles after the pin moves.
- R8: Filter select 1 sets a window of 64 cycles. A 63-cycle pulse is dropped and a steady change is flagged after 67 cycles.
- R9: Filter select 2 or 3 sets a window of 256 cycles. A 255-cycle pulse is dropped and a steady change is flagged after 259 cycles.
- R10: Any return of the filtered input to its accepted level inside the window restarts the count from zero.
- R11: A clear strobe with mask bit i clears flag i on the next edge. A detection in the same cycle takes priority over the clear.
- R12: While the cycle-rate enable is low, edge detection and filtering are frozen. A change that arrived meanwhile is detected on the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle-rate enable for filter and trigger stages |
| pin_i | input | NPIN | Raw external pins |
| mode_cfg | input | 3*NPIN | Trigger code per pin, pin i at bits 3i+2..3i |
| filt_sel | input | 2 | Filter window select for filtered pins |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | NPIN | Pins cleared by the strobe |
| flag_o | output | NPIN | Sticky interrupt flags |
| event_o | output | NPIN | One-cycle trigger strobes |

## Verification
A filter counter that starts from the wrong value, or that fails to restart, shows up at the ports as a flag that comes one or more cycles early or late. It can also show up as a pulse that is wrongly accepted. The bench therefore times every accepted change against window+3 and tests pulses one cycle shorter than the window. A stale previous-level register in the trigger stage produces a missing or doubled event within three cycles of the pin change. A broken set-over-clear priority shows up as a level flag that drops on the cycle after a clear.

// File: rtl/extint_pkg.sv
package extint_pkg;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_FALL = 3'd2,
      TRIG_BOTH = 3'd3,
      TRIG_HIGH = 3'd4,
      TRIG_LOW  = 3'd5
   } trig_e;

   localparam int TRIG_W = 3;

   function automatic logic is_level(input logic [TRIG_W-1:0] m);
      return (m == TRIG_HIGH) || (m == TRIG_LOW);
   endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage1_q;
   logic [WIDTH-1:0] stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= raw_i;
         stage2_q <= stage1_q;
      end
   end

   assign sync_o = stage2_q;

endmodule

// File: rtl/extint_filter.sv
module extint_filter #(
   parameter int TC_SHORT = 1,
   parameter int TC_MID   = 32,
   parameter int TC_LONG  = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_en,
   input  logic       raw_i,
   input  logic [1:0] sel_i,
   output logic       lvl_o
);

   localparam int WIN_MAX = 2 * TC_LONG;
   localparam int CW      = $clog2(WIN_MAX + 1);

   if (TC_SHORT < 1 || TC_MID <= TC_SHORT || TC_LONG <= TC_MID) begin : g_bad_tc
      $error("extint_filter: time constants must be ascending and at least 1");
   end

   logic [CW-1:0] win_m1;
   logic [CW-1:0] cnt_q;
   logic          lvl_q;

   always_comb begin
      case (sel_i)
         2'd0:    win_m1 = CW'(2 * TC_SHORT - 1);
         2'd1:    win_m1 = CW'(2 * TC_MID - 1);
         default: win_m1 = CW'(2 * TC_LONG - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (cyc_en) begin
         if (raw_i == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q >= win_m1) begin
            lvl_q <= raw_i;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign lvl_o = lvl_q;

   p_accept_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) >= $past(win_m1) && $past(cyc_en)));

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && raw_i == lvl_q) |=> (cnt_q == '0));

   p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_en |=> ($stable(cnt_q) && $stable(lvl_q)));

endmodule

// File: rtl/extint_trigger.sv
module extint_trigger
   import extint_pkg::*;
#(
   parameter bit LEVEL_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              lvl_i,
   input  logic [TRIG_W-1:0] mode_i,
   input  logic              clr_i,
   output logic              flag_o,
   output logic              evt_o
);

   logic prev_q;
   logic flag_q;
   logic evt_q;
   logic rise;
   logic fall;
   logic edge_hit;
   logic evt_hit;
   logic lvl_hit;
   logic lvl_mode_ok;

   if (LEVEL_OK) begin : g_level
      assign lvl_mode_ok = is_level(mode_i);
   end else begin : g_edge_only
      assign lvl_mode_ok = 1'b0;
   end

   assign rise = cyc_en &  lvl_i & ~prev_q;
   assign fall = cyc_en & ~lvl_i &  prev_q;

   always_comb begin
      edge_hit = 1'b0;
      evt_hit  = 1'b0;
      lvl_hit  = 1'b0;
      case (mode_i)
         TRIG_RISE: begin edge_hit = rise;        evt_hit = rise;        end
         TRIG_FALL: begin edge_hit = fall;        evt_hit = fall;        end
         TRIG_BOTH: begin edge_hit = rise | fall; evt_hit = rise | fall; end
         TRIG_HIGH: begin
            lvl_hit = lvl_mode_ok &  lvl_i;
            evt_hit = lvl_mode_ok &  rise;
         end
         TRIG_LOW: begin
            lvl_hit = lvl_mode_ok & ~lvl_i;
            evt_hit = lvl_mode_ok &  fall;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         if (cyc_en) prev_q <= lvl_i;
         flag_q <= (flag_q & ~clr_i) | edge_hit | lvl_hit;
         evt_q  <= evt_hit;
      end
   end

   assign flag_o = flag_q;
   assign evt_o  = evt_q;

   p_evt_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> flag_q);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && mode_i == TRIG_RISE && !(cyc_en && lvl_i && !prev_q)) |=> !flag_q);

   if (LEVEL_OK) begin : g_chk_level
      p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == TRIG_HIGH && lvl_i) |=> flag_q);
   end else begin : g_chk_edge
      p_no_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (is_level(mode_i) && !flag_q) |=> (!flag_q && !evt_q));
   end

endmodule

// File: rtl/extint_detect.sv
module extint_detect
   import extint_pkg::*;
#(
   parameter int             NPIN      = 6,
   parameter logic [NPIN-1:0] LEVEL_OK = 6'b000011,
   parameter logic [NPIN-1:0] FILT_MASK = 6'b001000,
   parameter int             TC_SHORT  = 1,
   parameter int             TC_MID    = 32,
   parameter int             TC_LONG   = 128
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cyc_en,
   input  logic [NPIN-1:0]        pin_i,
   input  logic [TRIG_W*NPIN-1:0] mode_cfg,
   input  logic [1:0]             filt_sel,
   input  logic                   clr_we,
   input  logic [NPIN-1:0]        clr_mask,
   output logic [NPIN-1:0]        flag_o,
   output logic [NPIN-1:0]        event_o
);

   if (NPIN < 1) begin : g_bad_npin
      $error("extint_detect: NPIN must be at least 1");
   end

   logic [NPIN-1:0] pin_sync;
   logic [NPIN-1:0] pin_lvl;
   logic [NPIN-1:0] clr_vec;

   assign clr_vec = clr_mask & {NPIN{clr_we}};

   extint_sync #(.WIDTH(NPIN)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_i),
      .sync_o (pin_sync)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      if (FILT_MASK[i]) begin : g_filt
         extint_filter #(
            .TC_SHORT (TC_SHORT),
            .TC_MID   (TC_MID),
            .TC_LONG  (TC_LONG)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .cyc_en (cyc_en),
            .raw_i  (pin_sync[i]),
            .sel_i  (filt_sel),
            .lvl_o  (pin_lvl[i])
         );
      end else begin : g_direct
         assign pin_lvl[i] = pin_sync[i];
      end

      extint_trigger #(.LEVEL_OK(LEVEL_OK[i])) u_trig (
         .clk    (clk),
         .rst_n  (rst_n),
         .cyc_en (cyc_en),
         .lvl_i  (pin_lvl[i]),
         .mode_i (mode_cfg[TRIG_W*i +: TRIG_W]),
         .clr_i  (clr_vec[i]),
         .flag_o (flag_o[i]),
         .evt_o  (event_o[i])
      );
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flag_o == '0 && event_o == '0));

endmodule

// File: tb/tb_extint_detect.sv
`timescale 1ns/1ps
module tb_extint_detect;
   localparam int NP = 6;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cyc_en;
   logic [NP-1:0]   pin_i;
   logic [3*NP-1:0] mode_cfg;
   logic [1:0]      filt_sel;
   logic            clr_we;
   logic [NP-1:0]   clr_mask;
   logic [NP-1:0]   flag_o;
   logic [NP-1:0]   event_o;

   always #2.5 clk = ~clk;

   extint_detect dut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .pin_i(pin_i),
      .mode_cfg(mode_cfg), .filt_sel(filt_sel), .clr_we(clr_we),
      .clr_mask(clr_mask), .flag_o(flag_o), .event_o(event_o)
   );

   typedef struct {
      int    at;
      int    pin;
      logic  flag;
      logic  evt;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
      end
   endtask

   // driver side: queue an expected pin state dly cycles from now
   task automatic expect_at(input int dly, input int pin, input logic f,
                            input logic e, input string tag);
      exp_t x;
      x.at = cyc + dly; x.pin = pin; x.flag = f; x.evt = e; x.tag = tag;
      q.push_back(x);
   endtask

   // monitor: compare every due item away from the active edge
   always @(negedge clk) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].at <= cyc) begin
            chk(q[i].tag, {30'd0, flag_o[q[i].pin], event_o[q[i].pin]},
                {30'd0, q[i].flag, q[i].evt});
            q.delete(i);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input int p, input logic [2:0] m);
      mode_cfg[3*p +: 3] = m;
   endtask

   task automatic clear_pins(input logic [NP-1:0] m);
      clr_we = 1'b1; clr_mask = m;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_run++; n_fail++;
      $display("FAIL watchdog expired, expected run to complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cyc_en = 1'b1; pin_i = '0; mode_cfg = '0;
      filt_sel = 2'd0; clr_we = 1'b0; clr_mask = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 flags", flag_o, 0);
      chk("R1 events", event_o, 0);

      set_mode(0, 3'd1); set_mode(1, 3'd2); set_mode(2, 3'd3); set_mode(3, 3'd1);
      tick(2);

      // R2 rising edge
      pin_i[0] = 1'b1;
      expect_at(2, 0, 0, 0, "R2 early");
      expect_at(3, 0, 1, 1, "R2 rise");
      expect_at(4, 0, 1, 0, "R2 pulse width");
      tick(6);
      pin_i[0] = 1'b0;
      expect_at(3, 0, 1, 0, "R2 fall ignored");
      tick(5);

      // R11 clear
      clr_we = 1'b1; clr_mask = 6'b000001;
      expect_at(1, 0, 0, 0, "R11 clear");
      tick(1); clr_we = 1'b0; clr_mask = '0;
      tick(3);

      // R3 falling edge
      pin_i[1] = 1'b1;
      expect_at(3, 1, 0, 0, "R3 rise ignored");
      tick(5);
      pin_i[1] = 1'b0;
      expect_at(3, 1, 1, 1, "R3 fall");
      tick(5);

      // R4 both edges, single-cycle pulse
      pin_i[2] = 1'b1;
      expect_at(3, 2, 1, 1, "R4 rise");
      tick(5);
      expect_at(1, 2, 0, 0, "R4 clear");
      clear_pins(6'b000100);
      tick(2);
      pin_i[2] = 1'b0;
      expect_at(3, 2, 1, 1, "R4 fall");
      tick(5);
      clear_pins(6'b000100);
      tick(2);
      pin_i[2] = 1'b1;
      expect_at(3, 2, 1, 1, "R4 short pulse rise");
      expect_at(4, 2, 1, 1, "R4 short pulse fall");
      expect_at(5, 2, 1, 0, "R4 pulse end");
      tick(1);
      pin_i[2] = 1'b0;
      tick(6);

      // R5 level high on pin 0
      set_mode(0, 3'd4);
      tick(2);
      pin_i[0] = 1'b1;
      expect_at(3, 0, 1, 1, "R5 high entry");
      expect_at(4, 0, 1, 0, "R5 event once");
      tick(6);
      expect_at(1, 0, 1, 0, "R5 clear ignored");
      clear_pins(6'b000001);
      tick(2);
      pin_i[0] = 1'b0;
      tick(5);
      expect_at(1, 0, 0, 0, "R5 clear after level");
      clear_pins(6'b000001);
      // R5 level low on pin 1, set beats clear (R11)
      set_mode(1, 3'd5);
      clr_we = 1'b1; clr_mask = 6'b000010;
      expect_at(1, 1, 1, 0, "R11 set wins, R5 low");
      tick(1); clr_we = 1'b0; clr_mask = '0;
      set_mode(1, 3'd0);
      tick(1);
      expect_at(1, 1, 0, 0, "R6 off code");
      clear_pins(6'b000010);

      // R6 level codes on edge-only pins
      set_mode(4, 3'd4); set_mode(5, 3'd5);
      expect_at(2, 5, 0, 0, "R6 low on edge-only pin");
      pin_i[4] = 1'b1;
      expect_at(3, 4, 0, 0, "R6 high on edge-only pin");
      expect_at(6, 4, 0, 0, "R6 high later");
      tick(8);
      set_mode(4, 3'd7);
      pin_i[4] = 1'b0;
      expect_at(3, 4, 0, 0, "R6 code 7 off");
      tick(5);

      // R12 enable gating
      set_mode(0, 3'd1);
      tick(2);
      cyc_en = 1'b0;
      pin_i[0] = 1'b1;
      expect_at(5, 0, 0, 0, "R12 frozen");
      tick(8);
      cyc_en = 1'b1;
      expect_at(1, 0, 1, 1, "R12 resumes");
      tick(3);
      pin_i[0] = 1'b0;
      tick(4);
      clear_pins(6'b000001);

      // R7 filter window 2
      filt_sel = 2'd0;
      pin_i[3] = 1'b1;
      expect_at(8, 3, 0, 0, "R7 one-cycle dropped");
      tick(1);
      pin_i[3] = 1'b0;
      tick(10);
      pin_i[3] = 1'b1;
      expect_at(4, 3, 0, 0, "R7 not early");
      expect_at(5, 3, 1, 1, "R7 two-cycle accepted");
      tick(2);
      pin_i[3] = 1'b0;
      tick(10);
      clear_pins(6'b001000);

      // R8 filter window 64
      filt_sel = 2'd1;
      pin_i[3] = 1'b1;
      expect_at(67, 3, 0, 0, "R8 63 dropped");
      tick(63);
      pin_i[3] = 1'b0;
      tick(70);
      pin_i[3] = 1'b1;
      expect_at(66, 3, 0, 0, "R8 not early");
      expect_at(67, 3, 1, 1, "R8 accepted");
      tick(75);
      pin_i[3] = 1'b0;
      tick(70);
      clear_pins(6'b001000);

      // R10 restart inside window
      pin_i[3] = 1'b1;
      expect_at(67, 3, 0, 0, "R10 glitch restarts");
      tick(40);
      pin_i[3] = 1'b0;
      tick(1);
      pin_i[3] = 1'b1;
      expect_at(66, 3, 0, 0, "R10 full window needed");
      expect_at(67, 3, 1, 1, "R10 accepted after restart");
      tick(75);
      pin_i[3] = 1'b0;
      tick(70);
      clear_pins(6'b001000);

      // R9 filter window 256
      filt_sel = 2'd2;
      pin_i[3] = 1'b1;
      expect_at(258, 3, 0, 0, "R9 not early");
      expect_at(259, 3, 1, 1, "R9 accepted");
      tick(265);
      pin_i[3] = 1'b0;
      tick(265);
      clear_pins(6'b001000);
      filt_sel = 2'd3;
      pin_i[3] = 1'b1;
      expect_at(262, 3, 0, 0, "R9 255 dropped sel3");
      tick(255);
      pin_i[3] = 1'b0;
      tick(270);

      chk("R1 scoreboard drained", q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule